// File: doc/BRIEF.md
# Hsync-Referenced Clamp Pulse Generator

This block makes one clamp pulse per video line for a front-end that restores black level. It watches the horizontal sync input in the pixel clock domain and finds the edge where sync goes from its active level back to inactive. From that edge it waits a programmed number of pixel clocks, then holds the clamp active for a programmed number of pixel clocks. The aim is to land the pulse on the back porch, where the input carries a stable black reference.

A source select can bypass the internal timing and pass an external clamp input through instead. The output polarity is either fixed active-high (automatic mode) or set by a user polarity bit. The configuration fields are plain inputs driven by a register block elsewhere in the chip. That register block holds the reset values placement = 8, duration = 20, override = 0 and user polarity = 1.

Top module: `clamp_pulse_gen`

## Requirements
- R1: `hs_act_hi` selects the active Hsync level (1 = active-high, 0 = active-low). Only a change of `hsync_in` from the active to the inactive level starts a line. A leading edge or a steady level starts no pulse.
- R2: With `clamp_src_ext` = 0, the clamp becomes active on the (P+2)th rising clock edge counted from the first edge that samples Hsync inactive, where P = `place_cfg`.
- R3: With `clamp_src_ext` = 0, the internal clamp stays active for exactly D = `dur_cfg` clock cycles and then returns to inactive.
- R4: A value of 0 in `place_cfg` or `dur_cfg` behaves exactly like a value of 1.
- R5: A trailing edge that arrives while a pulse is pending or active restarts the placement count from the new edge.
- R6: With `clamp_src_ext` = 1, the clamp follows `ext_clamp` one clock later (1 = clamp active). Hsync edges, `place_cfg` and `dur_cfg` then have no effect on the output.
- R7: With `pol_override` = 0, `clamp_out` is 1 while the clamp is active and 0 otherwise. With `pol_override` = 1, the active level is `pol_user`: 1 gives positive polarity, 0 gives negative polarity, and the inactive level is its complement.
- R8: While `rst_n` is low, and afterwards until a clamp is due, `clamp_out` holds the inactive level given by R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| hsync_in | input | 1 | Horizontal sync |
| hs_act_hi | input | 1 | Hsync active level, 1 = high |
| ext_clamp | input | 1 | External clamp, 1 = active |
| clamp_src_ext | input | 1 | 1 = use the external clamp, 0 = internal timing |
| place_cfg | input | 8 | Delay in pixel clocks from the trailing edge to the clamp start |
| dur_cfg | input | 8 | Clamp length in pixel clocks |
| pol_override | input | 1 | 1 = polarity taken from pol_user |
| pol_user | input | 1 | User polarity, 1 = positive |
| clamp_out | output | 1 | Clamp signal |

## Verification
A table of configurations is driven through one trailing edge each. The configurations mix the minimum, default and maximum placement and duration, zero fields, both Hsync polarities and all three output polarity settings. Comparing the measured start cycle and length with each entry separates a wrong delay from a wrong width, and separates an edge taken from the wrong sync level from an output inverted at the wrong stage. Directed tests then hold Hsync active with no trailing edge, and insert a second trailing edge while a pulse is pending, which shows whether the count restarts. A final test selects the external source with Hsync edges present, which shows whether the internal timer leaks to the output.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

  typedef enum logic [1:0] {
    CT_IDLE = 2'd0,
    CT_WAIT = 2'd1,
    CT_ACT  = 2'd2
  } clamp_state_e;

  // Level that clamp_out takes while the clamp is active
  function automatic logic active_level(input logic ovr, input logic usr);
    return ovr ? usr : 1'b1;
  endfunction

endpackage

// File: rtl/hsync_edge_det.sv
module hsync_edge_det #(
  parameter int unsigned SYNC_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_in,
  input  logic hs_act_hi,
  output logic trail
);

  logic [SYNC_STAGES:0] sh;
  logic                 hs_cur;
  logic                 hs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh[0] <= ~hs_act_hi;
    else        sh[0] <= hsync_in;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh[g] <= ~hs_act_hi;
      else        sh[g] <= sh[g-1];
    end
  end

  assign hs_cur  = sh[SYNC_STAGES-1];
  assign hs_prev = sh[SYNC_STAGES];
  assign trail   = (hs_prev == hs_act_hi) && (hs_cur != hs_act_hi);

  AST_TRAIL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trail |=> !trail); // R1

endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
  import clamp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trail,
  input  logic [W-1:0] place_cfg,
  input  logic [W-1:0] dur_cfg,
  output logic         int_pulse
);

  function automatic logic [W-1:0] floor_one(input logic [W-1:0] v);
    return (v == '0) ? W'(1) : v;
  endfunction

  clamp_state_e state;
  logic [W-1:0] cnt;
  logic [W-1:0] p_eff;
  logic [W-1:0] d_eff;
  logic         wait_done;
  logic         act_done;

  assign p_eff     = floor_one(place_cfg);
  assign d_eff     = floor_one(dur_cfg);
  assign wait_done = (state == CT_WAIT) && (cnt == '0);
  assign act_done  = (state == CT_ACT) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CT_IDLE;
      cnt   <= '0;
    end else if (trail) begin
      state <= CT_WAIT;
      cnt   <= p_eff - W'(1);
    end else begin
      unique case (state)
        CT_WAIT: begin
          if (wait_done) begin
            state <= CT_ACT;
            cnt   <= d_eff - W'(1);
          end else begin
            cnt <= cnt - W'(1);
          end
        end
        CT_ACT: begin
          if (act_done) state <= CT_IDLE;
          else          cnt   <= cnt - W'(1);
        end
        default: state <= CT_IDLE;
      endcase
    end
  end

  assign int_pulse = (state == CT_ACT);

  // Length of the current active run, for the width check
  logic [W:0] act_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              act_run <= '0;
    else if (state == CT_ACT) act_run <= act_run + 1'b1;
    else                     act_run <= '0;
  end

  AST_RESTART_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    trail |=> (state == CT_WAIT)); // R5

  AST_NO_ACT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CT_IDLE && !trail) |=> (state != CT_ACT)); // R2

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CT_ACT) |-> (act_run < {1'b0, d_eff})); // R3

  AST_ZERO_AS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CT_WAIT) |-> (cnt < p_eff)); // R4

endmodule

// File: rtl/clamp_out_stage.sv
module clamp_out_stage
  import clamp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic int_pulse,
  input  logic ext_clamp,
  input  logic clamp_src_ext,
  input  logic pol_override,
  input  logic pol_user,
  output logic clamp_out
);

  logic clamp_act;
  logic lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clamp_act <= 1'b0;
    else        clamp_act <= clamp_src_ext ? ext_clamp : int_pulse;
  end

  assign lvl       = active_level(pol_override, pol_user);
  assign clamp_out = clamp_act ? lvl : ~lvl;

  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_src_ext |=> (clamp_act == $past(ext_clamp))); // R6

  AST_INT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_src_ext |=> (clamp_act == $past(int_pulse))); // R2

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
  parameter int unsigned CFG_W       = 8,
  parameter int unsigned SYNC_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_in,
  input  logic             hs_act_hi,
  input  logic             ext_clamp,
  input  logic             clamp_src_ext,
  input  logic [CFG_W-1:0] place_cfg,
  input  logic [CFG_W-1:0] dur_cfg,
  input  logic             pol_override,
  input  logic             pol_user,
  output logic             clamp_out
);

  logic trail;
  logic int_pulse;

  hsync_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync_in  (hsync_in),
    .hs_act_hi (hs_act_hi),
    .trail     (trail)
  );

  clamp_timer #(.W(CFG_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .trail     (trail),
    .place_cfg (place_cfg),
    .dur_cfg   (dur_cfg),
    .int_pulse (int_pulse)
  );

  clamp_out_stage u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .int_pulse     (int_pulse),
    .ext_clamp     (ext_clamp),
    .clamp_src_ext (clamp_src_ext),
    .pol_override  (pol_override),
    .pol_user      (pol_user),
    .clamp_out     (clamp_out)
  );

endmodule

// File: tb/clamp_pulse_gen_bench.sv
`timescale 1ns/1ps
module clamp_pulse_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_in = 1'b0;
  logic       hs_act_hi = 1'b1;
  logic       ext_clamp = 1'b0;
  logic       clamp_src_ext = 1'b0;
  logic [7:0] place_cfg = 8'd8;
  logic [7:0] dur_cfg = 8'd20;
  logic       pol_override = 1'b0;
  logic       pol_user = 1'b1;
  logic       clamp_out;

  always #2.5 clk = ~clk;

  clamp_pulse_gen u_clamp_pulse_gen (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .hs_act_hi(hs_act_hi),
    .ext_clamp(ext_clamp), .clamp_src_ext(clamp_src_ext),
    .place_cfg(place_cfg), .dur_cfg(dur_cfg),
    .pol_override(pol_override), .pol_user(pol_user), .clamp_out(clamp_out)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  logic exp_lvl = 1'b1;
  bit armed = 0, seen = 0, ended = 0;
  int first = 0, len = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Measures the first active run of clamp_out after arming
  always @(negedge clk) begin
    if (armed) begin
      if ((clamp_out === exp_lvl) && !seen) begin seen = 1; first = cyc; end
      if ((clamp_out === exp_lvl) && seen && !ended) len = len + 1;
      if (seen && (clamp_out !== exp_lvl)) ended = 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm();
    @(posedge clk);
    seen = 0; ended = 0; len = 0; first = 0; armed = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int eff(input int v);
    return v + ((v == 0) ? 1 : 0);
  endfunction

  // {place, dur, hs_act_hi, pol_override, pol_user}
  localparam logic [18:0] VEC [6] = '{
    {8'd8,   8'd20,  1'b1, 1'b0, 1'b1},
    {8'd1,   8'd1,   1'b1, 1'b1, 1'b1},
    {8'd0,   8'd0,   1'b0, 1'b0, 1'b1},
    {8'd255, 8'd3,   1'b0, 1'b1, 1'b0},
    {8'd3,   8'd255, 1'b1, 1'b1, 1'b0},
    {8'd5,   8'd7,   1'b0, 1'b0, 1'b0}
  };

  initial begin
    int c;
    // R8: reset level with negative polarity, then automatic polarity
    pol_override = 1'b1; pol_user = 1'b0;
    idle(3);
    check("R8 reset level negative", int'(clamp_out), 1);
    pol_override = 1'b0;
    idle(1);
    check("R8 reset level auto", int'(clamp_out), 0);
    rst_n = 1'b1;
    idle(5);
    check("R8 idle after reset", int'(clamp_out), 0);

    for (int i = 0; i < 6; i++) begin
      int p, d;
      p = int'(VEC[i][18:11]); d = int'(VEC[i][10:3]);
      @(negedge clk);
      armed = 0;
      place_cfg = VEC[i][18:11]; dur_cfg = VEC[i][10:3];
      hs_act_hi = VEC[i][2]; pol_override = VEC[i][1]; pol_user = VEC[i][0];
      hsync_in = ~VEC[i][2];
      exp_lvl = VEC[i][1] ? VEC[i][0] : 1'b1;
      idle(600);
      arm();
      @(negedge clk); hsync_in = VEC[i][2];
      idle(3);
      hsync_in = ~VEC[i][2]; c = cyc;
      idle(eff(p) + eff(d) + 12);
      check($sformatf("R2 R4 R7 start vec%0d", i), first, c + eff(p) + 3);
      check($sformatf("R3 R4 R7 width vec%0d", i), len, eff(d));
    end

    // R1: leading edge and steady active level give no pulse
    @(negedge clk);
    armed = 0; place_cfg = 8'd4; dur_cfg = 8'd4; hs_act_hi = 1'b1;
    pol_override = 1'b0; exp_lvl = 1'b1; hsync_in = 1'b0;
    idle(600);
    arm();
    @(negedge clk); hsync_in = 1'b1;
    idle(40);
    check("R1 no pulse on leading edge", int'(seen), 0);

    // R5: second trailing edge while pending restarts the count
    @(negedge clk);
    place_cfg = 8'd10; dur_cfg = 8'd4;
    hsync_in = 1'b0;
    idle(5);
    hsync_in = 1'b1;
    idle(2);
    hsync_in = 1'b0; c = cyc;
    idle(30);
    check("R5 restart start", first, c + 10 + 3);
    check("R5 restart width", len, 4);

    // R6: external source; Hsync edge alone gives nothing
    @(negedge clk);
    armed = 0; clamp_src_ext = 1'b1; place_cfg = 8'd2; dur_cfg = 8'd3;
    hsync_in = 1'b1;
    idle(4);
    arm();
    @(negedge clk); hsync_in = 1'b0;
    idle(30);
    check("R6 hsync ignored in external mode", int'(seen), 0);
    ext_clamp = 1'b1; c = cyc;
    idle(6);
    ext_clamp = 1'b0;
    idle(5);
    check("R6 external start", first, c + 1);
    check("R6 external width", len, 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule